// File: doc/BRIEF.md
# Request-Grant Handshake Runtime Monitor

This block watches two single-bit signals, a request `req` and a grant `gnt`, and checks one temporal rule on every clock. An attempt opens when `req` is low in one cycle and high in the next. From the following cycle, the request may stay asserted without a grant for at most two cycles. After that a grant must arrive. The monitor reports, one cycle later, whether each attempt completed (a `pass` pulse) or broke the rule (a `fail` pulse).

Internally each open attempt is held as a thread in a slot indexed by its age, meaning the number of request-only cycles it has used so far. The parameter `MAX_REPEAT` sets how many request-only cycles are allowed, and the number of slots follows from it. A new attempt is tracked apart from any attempt that resolves in the same cycle. The block drops into a larger design as a passive observer: it takes the two signals and drives only its two verdict pulses.

Top module: `rgmon_reqgnt`

## Requirements
- R1: A synchronous active-high reset clears every open attempt and drives `pass` and `fail` low. An attempt that is pending when reset is applied produces no verdict.
- R2: An attempt opens only in a cycle where `req` is high and was low in the previous cycle. `req` held high over several cycles opens nothing more. The first cycle after reset cannot open an attempt, because no previous value of `req` has been seen.
- R3: When `gnt` is high in the first cycle after the opening cycle, `pass` is high for exactly the next cycle.
- R4: Cycles with `req` high and `gnt` low keep an attempt open, up to `MAX_REPEAT` (default 2) of them in a row. A `gnt` in the cycle after one or two such cycles gives a `pass` pulse one cycle later.
- R5: A checked cycle of an open attempt with both `req` and `gnt` low gives a `fail` pulse one cycle later.
- R6: For an open attempt that has already used `MAX_REPEAT` request-only cycles, a following cycle without `gnt` gives a `fail` pulse one cycle later, whatever the value of `req`.
- R7: An attempt that opens in the cycle right after an earlier attempt resolved is tracked independently and receives its own verdict. At most one attempt is ever open at a time.
- R8: `pass` and `fail` are registered single-cycle pulses. They are never high in the same cycle and never high in two consecutive cycles.
- R9: A `gnt` in the opening cycle itself does not count toward the attempt. Checking starts in the cycle after the opening cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| req | input | 1 | Observed request signal |
| gnt | input | 1 | Observed grant signal |
| pass | output | 1 | One-cycle pulse: an attempt completed with a grant |
| fail | output | 1 | One-cycle pulse: an attempt broke the rule |

## Verification
The bound checker watches the following on every cycle:
- `pass` and `fail` never coincide and never last more than one cycle.
- At most one slot is occupied.
- An opening followed at once by a grant always yields `pass`.
- An opening followed by an idle cycle always yields `fail`.
- An opening followed by two request-only cycles and a missing grant always yields `fail`.

The bench's scenarios cover what the checker does not:
- A grant in the opening cycle is ignored.
- Held requests do not re-open an attempt.
- The first cycle after reset cannot open an attempt.
- Reset in the middle of an attempt discards it.
- A new attempt opened right after a pass is judged by its own outcome.

A long pseudo-random stream, compared cycle by cycle against a behavioural model, exercises the mixes the directed cases do not reach.

// File: rtl/rgmon_pkg.sv
package rgmon_pkg;

  typedef enum logic [1:0] {
    VERDICT_NONE = 2'd0,
    VERDICT_PASS = 2'd1,
    VERDICT_FAIL = 2'd2
  } verdict_e;

endpackage

// File: rtl/rgmon_trigger.sv
// Detects the opening edge of an attempt: req low in the previous
// sampled cycle and high in the current one. The history flag keeps
// the first cycle after reset from ever opening an attempt.
module rgmon_trigger (
  input  logic clk,
  input  logic rst,
  input  logic req,
  output logic start
);

  logic req_q;
  logic hist_vld;

  always_ff @(posedge clk) begin
    if (rst) begin
      req_q    <= 1'b0;
      hist_vld <= 1'b0;
    end else begin
      req_q    <= req;
      hist_vld <= 1'b1;
    end
  end

  assign start = hist_vld & ~req_q & req;

endmodule

// File: rtl/rgmon_slot.sv
// One thread slot. A slot is occupied when an attempt of its age is
// open in the current cycle. The verdict is combinational on the
// current req/gnt samples. The final slot has no request-only cycles left.
module rgmon_slot
  import rgmon_pkg::*;
#(
  parameter bit FINAL = 1'b0
) (
  input  logic     clk,
  input  logic     rst,
  input  logic     arm,
  input  logic     req,
  input  logic     gnt,
  output logic     alive,
  output verdict_e verdict
);

  always_ff @(posedge clk) begin
    if (rst) alive <= 1'b0;
    else     alive <= arm;
  end

  always_comb begin
    verdict = VERDICT_NONE;
    if (alive) begin
      if (gnt)                verdict = VERDICT_PASS;
      else if (req && !FINAL) verdict = VERDICT_NONE;
      else                    verdict = VERDICT_FAIL;
    end
  end

endmodule

// File: rtl/rgmon_verdict.sv
// Merges per-slot verdicts into registered pass/fail pulses.
module rgmon_verdict
  import rgmon_pkg::*;
#(
  parameter int SLOTS = 3
) (
  input  logic     clk,
  input  logic     rst,
  input  verdict_e verdicts [SLOTS],
  output logic     pass,
  output logic     fail
);

  logic pass_d;
  logic fail_d;

  always_comb begin
    pass_d = 1'b0;
    fail_d = 1'b0;
    for (int i = 0; i < SLOTS; i++) begin
      if (verdicts[i] == VERDICT_PASS) pass_d = 1'b1;
      if (verdicts[i] == VERDICT_FAIL) fail_d = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pass <= 1'b0;
      fail <= 1'b0;
    end else begin
      pass <= pass_d;
      fail <= fail_d;
    end
  end

endmodule

// File: rtl/rgmon_reqgnt.sv
// Runtime monitor: after req rises, req may stay high for up to
// MAX_REPEAT cycles with no grant, and then gnt must be seen.
module rgmon_reqgnt
  import rgmon_pkg::*;
#(
  parameter int MAX_REPEAT = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic req,
  input  logic gnt,
  output logic pass,
  output logic fail
);

  localparam int SLOTS = MAX_REPEAT + 1;

  logic             start;
  logic [SLOTS-1:0] slot_alive;
  logic [SLOTS-1:0] slot_arm;
  verdict_e         slot_verdict [SLOTS];

  rgmon_trigger u_trigger (
    .clk   (clk),
    .rst   (rst),
    .req   (req),
    .start (start)
  );

  assign slot_arm[0] = start;

  // A slot arms from the opening edge (slot 0) or from a younger
  // thread that saw a request-only cycle.
  for (genvar g = 1; g < SLOTS; g++) begin : g_arm
    assign slot_arm[g] = slot_alive[g-1] & req & ~gnt;
  end

  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    rgmon_slot #(
      .FINAL (g == SLOTS - 1)
    ) u_slot (
      .clk     (clk),
      .rst     (rst),
      .arm     (slot_arm[g]),
      .req     (req),
      .gnt     (gnt),
      .alive   (slot_alive[g]),
      .verdict (slot_verdict[g])
    );
  end

  rgmon_verdict #(
    .SLOTS (SLOTS)
  ) u_verdict (
    .clk      (clk),
    .rst      (rst),
    .verdicts (slot_verdict),
    .pass     (pass),
    .fail     (fail)
  );

endmodule

// File: rtl/rgmon_reqgnt_chk.sv
module rgmon_reqgnt_chk #(
  parameter int SLOTS = 3
) (
  input logic             clk,
  input logic             rst,
  input logic             req,
  input logic             gnt,
  input logic             pass,
  input logic             fail,
  input logic [SLOTS-1:0] slot_alive
);

  // Cycles since reset, saturating; gates the $past look-back.
  logic [2:0] cyc;
  always_ff @(posedge clk) begin
    if (rst)              cyc <= 3'd0;
    else if (cyc != 3'd7) cyc <= cyc + 3'd1;
  end

  assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (rst)
    (cyc == 3'd0) |-> (!pass && !fail));

  assert_exclusive_R8: assert property (@(posedge clk) disable iff (rst)
    !(pass && fail));

  assert_pass_pulse_R8: assert property (@(posedge clk) disable iff (rst)
    pass |=> !pass);

  assert_fail_pulse_R8: assert property (@(posedge clk) disable iff (rst)
    fail |=> !fail);

  assert_single_thread_R7: assert property (@(posedge clk) disable iff (rst)
    $onehot0(slot_alive));

  assert_first_grant_R3: assert property (@(posedge clk) disable iff (rst)
    (cyc >= 3'd2 && !$past(req, 2) && $past(req) && gnt) |=> pass);

  assert_idle_cycle_R5: assert property (@(posedge clk) disable iff (rst)
    (cyc >= 3'd2 && !$past(req, 2) && $past(req) && !req && !gnt) |=> fail);

  assert_third_request_R6: assert property (@(posedge clk) disable iff (rst)
    (cyc >= 3'd4 && !$past(req, 4) && $past(req, 3)
     && $past(req, 2) && !$past(gnt, 2)
     && $past(req) && !$past(gnt) && !gnt) |=> fail);

endmodule

bind rgmon_reqgnt rgmon_reqgnt_chk #(.SLOTS(SLOTS)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .req        (req),
  .gnt        (gnt),
  .pass       (pass),
  .fail       (fail),
  .slot_alive (slot_alive)
);

// File: tb/test_rgmon_reqgnt.sv
`timescale 1ns/1ps
module test_rgmon_reqgnt;

  localparam int MAX_REPEAT = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req = 1'b0;
  logic gnt = 1'b0;
  logic pass;
  logic fail;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // Behavioural model state
  int ages[$];
  bit m_prev_req = 1'b0;
  bit m_prev_vld = 1'b0;
  bit exp_pass = 1'b0;
  bit exp_fail = 1'b0;

  always #4 clk = ~clk;

  rgmon_reqgnt #(.MAX_REPEAT(MAX_REPEAT)) i_rgmon_reqgnt (
    .clk  (clk),
    .rst  (rst),
    .req  (req),
    .gnt  (gnt),
    .pass (pass),
    .fail (fail)
  );

  task automatic model_edge(input bit r_rst, input bit r, input bit g);
    int nxt[$];
    exp_pass = 1'b0;
    exp_fail = 1'b0;
    if (r_rst) begin
      ages.delete();
      m_prev_vld = 1'b0;
      m_prev_req = 1'b0;
      return;
    end
    foreach (ages[k]) begin
      if (g)                            exp_pass = 1'b1;
      else if (r && ages[k] < MAX_REPEAT) nxt.push_back(ages[k] + 1);
      else                              exp_fail = 1'b1;
    end
    if (m_prev_vld && !m_prev_req && r) nxt.push_back(0);
    m_prev_req = r;
    m_prev_vld = 1'b1;
    ages = nxt;
  endtask

  task automatic check(input string tag, input string what,
                       input logic act, input bit exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%b expected=%b at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic step(input bit r_rst, input bit r, input bit g, input string tag);
    @(negedge clk);
    rst = r_rst;
    req = r;
    gnt = g;
    model_edge(r_rst, r, g);
    @(posedge clk);
    #1;
    check(tag, "pass", pass, exp_pass);
    check(tag, "fail", fail, exp_fail);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, errors);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      summary();
      $finish;
    end
  end

  initial begin
    logic [15:0] lfsr;
    // R1: reset state
    step(1, 0, 0, "R1");
    step(1, 1, 1, "R1");
    // R2: first cycle after reset with req high opens nothing; held req opens nothing
    step(0, 1, 0, "R2");
    step(0, 1, 0, "R2");
    step(0, 1, 0, "R2");
    step(0, 1, 0, "R2");
    // R3: grant right after opening
    step(0, 0, 0, "R3");
    step(0, 1, 0, "R3");
    step(0, 0, 1, "R3");
    step(0, 0, 0, "R3");
    // R4: one request-only cycle then grant
    step(0, 1, 0, "R4");
    step(0, 1, 0, "R4");
    step(0, 0, 1, "R4");
    step(0, 0, 0, "R4");
    // R4: two request-only cycles then grant (with req still high)
    step(0, 1, 0, "R4");
    step(0, 1, 0, "R4");
    step(0, 1, 0, "R4");
    step(0, 1, 1, "R4");
    step(0, 0, 0, "R4");
    // R5: idle cycle in obligation
    step(0, 1, 0, "R5");
    step(0, 0, 0, "R5");
    step(0, 0, 0, "R5");
    // R6: third request-only cycle
    step(0, 1, 0, "R6");
    step(0, 1, 0, "R6");
    step(0, 1, 0, "R6");
    step(0, 1, 0, "R6");
    step(0, 0, 0, "R6");
    // R9: grant on the opening cycle does not count
    step(0, 1, 1, "R9");
    step(0, 0, 0, "R9");
    step(0, 0, 0, "R9");
    // R7: back-to-back attempts, second judged on its own
    step(0, 1, 0, "R7");
    step(0, 0, 1, "R7");
    step(0, 1, 0, "R7");
    step(0, 0, 0, "R7");
    step(0, 0, 0, "R7");
    // R1: reset mid-attempt discards it
    step(0, 1, 0, "R1");
    step(1, 0, 0, "R1");
    step(0, 0, 0, "R1");
    step(0, 0, 0, "R1");
    // R8: pseudo-random stream against the model
    lfsr = 16'hACE1;
    for (int n = 0; n < 3000; n++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      step((lfsr[11:4] == 8'd0), lfsr[0], (lfsr[3:2] == 2'd0), "R8");
    end
    done = 1'b1;
    summary();
    $finish;
  end

endmodule